// File: doc/BRIEF.md
# GPIO Controller with Per-Pin Interrupt Detection

This block drives and samples a bank of general-purpose pins on behalf of a processor. Software reaches it through a synchronous register port addressed by 32-bit word. Through that port it sets the pad data and pad drive-enable of every pin and reads back the synchronized pin levels. Data and drive-enable can each be written whole, or changed a bit at a time through a set alias and a clear alias. With the aliases one pin can change without a read-modify-write sequence.

Each pin has a configuration word. The word picks a trigger condition: rising, falling or either edge, or low or high level. It also holds a routing field that decides whether the pin can raise the processor interrupt. Once a trigger condition occurs, a per-pin status flag holds until software clears it through the status clear alias. A level condition that still holds sets the flag again in every cycle. The single interrupt output is the OR, over all pins, of a pending flag together with a routing field equal to 1.

Top module: `gpio_irq_ctrl`

## Requirements
- R1: After reset, pad_out, pad_oe, irq, the interrupt status and every configuration word read as 0.
- R2: Word address 1 (byte 0x04) holds the pad data and is written whole. Word 2 (0x08) ORs the written bits into it. Word 3 (0x0C) clears the bits written as 1. A 0 bit leaves the data unchanged. pad_out shows the register in the cycle after the write.
- R3: Word address 8 (byte 0x20) holds the pad drive-enable and is written whole. Word 9 (0x24) sets bits in it and word 10 (0x28) clears bits in it, with the same rules as R2. The result drives pad_oe.
- R4: Reading word 15 (byte 0x3C) returns pin_in after a two-flop synchronizer. Bit n is pin n, and bits at and above NPIN read 0.
- R5: Pin n's configuration word sits at word address 29+n (byte 0x74+4n), for n below NPIN. It keeps bits 9:7 (trigger code) and bits 17:13 (routing field), and all other bits read 0.
- R6: Trigger code 1 sets the pin's status bit on a rising synchronized edge. Code 2 sets it on a falling edge, and code 3 on either edge.
- R7: Trigger code 4 sets the status bit in every cycle the synchronized level is 0, and code 5 in every cycle it is 1. A clear issued while the level still holds leaves the bit set.
- R8: A status bit stays set until 1 is written to that bit at word address 19 (byte 0x4C). Bits written as 0 are untouched.
- R9: Word 17 (byte 0x44) reads the status and a write replaces it. A write to word 18 (byte 0x48) ORs bits into it. A trigger in the same cycle still sets its bit.
- R10: irq is 1 exactly when some pin has its status bit set and a routing field of 1. Other routing values, such as 2, never raise irq.
- R11: Trigger codes 0, 6 and 7 never set a status bit.
- R12: Reads of the six alias addresses, of any unmapped address, and of any address while bus_en is 0 return 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_en | input | 1 | Register access strobe |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_addr | input | ADDR_W | Word address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid in the cycle of the access |
| pin_in | input | NPIN | Asynchronous pin levels |
| pad_out | output | NPIN | Pad data |
| pad_oe | output | NPIN | Pad drive-enable |
| irq | output | 1 | Processor interrupt request |

## Verification
The hardest case to reach is a clear that loses to a level trigger still holding. The bench has to keep a configured level at the pin through the synchronizer delay and then issue the clear. It must show that the flag survives, and that after the level falls a second clear removes the flag. A related case is an edge that crosses the two synchronizer flops: the bench changes a pin between clock edges and reads the status only after three edges. At that point both flops and the status register have moved. The bench runs every trigger code, including the unused ones, on pins whose routing both allows and blocks irq.

// File: rtl/gpioc_pkg.sv
package gpioc_pkg;

    localparam int unsigned DATA_W = 32;

    // word addresses (byte offset / 4)
    localparam int unsigned A_OUT     = 1;
    localparam int unsigned A_OUT_SET = 2;
    localparam int unsigned A_OUT_CLR = 3;
    localparam int unsigned A_OE      = 8;
    localparam int unsigned A_OE_SET  = 9;
    localparam int unsigned A_OE_CLR  = 10;
    localparam int unsigned A_IN      = 15;
    localparam int unsigned A_ST      = 17;
    localparam int unsigned A_ST_SET  = 18;
    localparam int unsigned A_ST_CLR  = 19;
    localparam int unsigned A_CFG0    = 29;

    // configuration word field placement
    localparam int unsigned KIND_LSB  = 7;
    localparam int unsigned ROUTE_LSB = 13;

    typedef enum logic [2:0] {
        TRG_OFF  = 3'd0,
        TRG_RISE = 3'd1,
        TRG_FALL = 3'd2,
        TRG_ANY  = 3'd3,
        TRG_LOW  = 3'd4,
        TRG_HIGH = 3'd5
    } trig_e;

    typedef enum logic [3:0] {
        SEL_NONE,
        SEL_OUT, SEL_OUT_SET, SEL_OUT_CLR,
        SEL_OE,  SEL_OE_SET,  SEL_OE_CLR,
        SEL_IN,
        SEL_ST,  SEL_ST_SET,  SEL_ST_CLR,
        SEL_CFG
    } reg_sel_e;

    typedef struct packed {
        logic [4:0] route;
        logic [2:0] kind;
    } pin_cfg_t;

    function automatic logic trig_hit(logic [2:0] kind, logic cur, logic prv);
        case (kind)
            TRG_RISE: return cur & ~prv;
            TRG_FALL: return ~cur & prv;
            TRG_ANY:  return cur ^ prv;
            TRG_LOW:  return ~cur;
            TRG_HIGH: return cur;
            default:  return 1'b0;
        endcase
    endfunction

    function automatic pin_cfg_t word_to_cfg(logic [DATA_W-1:0] w);
        pin_cfg_t c;
        c.route = w[ROUTE_LSB +: 5];
        c.kind  = w[KIND_LSB +: 3];
        return c;
    endfunction

    function automatic logic [DATA_W-1:0] cfg_to_word(pin_cfg_t c);
        logic [DATA_W-1:0] w;
        w = '0;
        w[ROUTE_LSB +: 5] = c.route;
        w[KIND_LSB +: 3]  = c.kind;
        return w;
    endfunction

endpackage

// File: rtl/gpioc_sync.sv
module gpioc_sync #(
    parameter int unsigned W      = 26,
    parameter int unsigned STAGES = 2
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [W-1:0] stg [STAGES];

    for (genvar s = 0; s < STAGES; s++) begin : g_stage
        if (s == 0) begin : g_first
            always_ff @(posedge clk) begin
                if (rst) stg[s] <= '0;
                else     stg[s] <= d;
            end
        end else begin : g_next
            always_ff @(posedge clk) begin
                if (rst) stg[s] <= '0;
                else     stg[s] <= stg[s-1];
            end
        end
    end

    assign q = stg[STAGES-1];
endmodule

// File: rtl/gpioc_decode.sv
module gpioc_decode
    import gpioc_pkg::*;
#(
    parameter int unsigned NPIN   = 26,
    parameter int unsigned ADDR_W = 8,
    localparam int unsigned CIDX_W = (NPIN > 1) ? $clog2(NPIN) : 1
) (
    input  logic [ADDR_W-1:0] addr,
    output reg_sel_e          sel,
    output logic [CIDX_W-1:0] cfg_idx
);
    int unsigned a;

    always_comb begin
        a       = int'(addr);
        sel     = SEL_NONE;
        cfg_idx = '0;
        case (a)
            A_OUT:     sel = SEL_OUT;
            A_OUT_SET: sel = SEL_OUT_SET;
            A_OUT_CLR: sel = SEL_OUT_CLR;
            A_OE:      sel = SEL_OE;
            A_OE_SET:  sel = SEL_OE_SET;
            A_OE_CLR:  sel = SEL_OE_CLR;
            A_IN:      sel = SEL_IN;
            A_ST:      sel = SEL_ST;
            A_ST_SET:  sel = SEL_ST_SET;
            A_ST_CLR:  sel = SEL_ST_CLR;
            default: begin
                if (a >= A_CFG0 && a < A_CFG0 + NPIN) begin
                    sel     = SEL_CFG;
                    cfg_idx = CIDX_W'(a - A_CFG0);
                end
            end
        endcase
    end
endmodule

// File: rtl/gpioc_detect.sv
module gpioc_detect
    import gpioc_pkg::*;
#(
    parameter int unsigned NPIN = 26
) (
    input  logic                      clk,
    input  logic                      rst,
    input  logic [NPIN-1:0]           lvl,
    input  pin_cfg_t [NPIN-1:0]       cfg,
    output logic [NPIN-1:0]           hit
);
    logic [NPIN-1:0] prv_q;

    always_ff @(posedge clk) begin
        if (rst) prv_q <= '0;
        else     prv_q <= lvl;
    end

    for (genvar i = 0; i < NPIN; i++) begin : g_pin
        assign hit[i] = trig_hit(cfg[i].kind, lvl[i], prv_q[i]);

        // R11
        kind_unused_chk: assert property (@(posedge clk) disable iff (rst)
            (cfg[i].kind == 3'd0 || cfg[i].kind == 3'd6 || cfg[i].kind == 3'd7) |-> !hit[i]);
    end
endmodule

// File: rtl/gpio_irq_ctrl.sv
module gpio_irq_ctrl
    import gpioc_pkg::*;
#(
    parameter int unsigned NPIN   = 26,
    parameter int unsigned ADDR_W = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              bus_en,
    input  logic              bus_we,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [31:0]       bus_wdata,
    output logic [31:0]       bus_rdata,
    input  logic [NPIN-1:0]   pin_in,
    output logic [NPIN-1:0]   pad_out,
    output logic [NPIN-1:0]   pad_oe,
    output logic              irq
);
    localparam int unsigned CIDX_W = (NPIN > 1) ? $clog2(NPIN) : 1;

    reg_sel_e            sel;
    logic [CIDX_W-1:0]   cfg_idx;
    logic                wr;
    logic [NPIN-1:0]     pin_mask;
    logic [NPIN-1:0]     lvl_s;
    logic [NPIN-1:0]     hit;
    logic [NPIN-1:0]     out_q, oe_q, st_q, st_d;
    logic [NPIN-1:0]     route_on;
    pin_cfg_t [NPIN-1:0] cfg_q;
    logic                st_wr_any;
    logic                wdata_unused;

    assign wr           = bus_en & bus_we;
    assign pin_mask     = bus_wdata[NPIN-1:0];
    assign wdata_unused = ^bus_wdata;

    gpioc_decode #(.NPIN(NPIN), .ADDR_W(ADDR_W)) u_dec (
        .addr    (bus_addr),
        .sel     (sel),
        .cfg_idx (cfg_idx)
    );

    gpioc_sync #(.W(NPIN), .STAGES(2)) u_sync (
        .clk (clk),
        .rst (rst),
        .d   (pin_in),
        .q   (lvl_s)
    );

    gpioc_detect #(.NPIN(NPIN)) u_det (
        .clk (clk),
        .rst (rst),
        .lvl (lvl_s),
        .cfg (cfg_q),
        .hit (hit)
    );

    // pad data and drive-enable
    always_ff @(posedge clk) begin
        if (rst) begin
            out_q <= '0;
            oe_q  <= '0;
        end else if (wr) begin
            case (sel)
                SEL_OUT:     out_q <= pin_mask;
                SEL_OUT_SET: out_q <= out_q | pin_mask;
                SEL_OUT_CLR: out_q <= out_q & ~pin_mask;
                SEL_OE:      oe_q  <= pin_mask;
                SEL_OE_SET:  oe_q  <= oe_q | pin_mask;
                SEL_OE_CLR:  oe_q  <= oe_q & ~pin_mask;
                default: ;
            endcase
        end
    end

    // configuration words
    always_ff @(posedge clk) begin
        if (rst)                      cfg_q          <= '0;
        else if (wr && sel == SEL_CFG) cfg_q[cfg_idx] <= word_to_cfg(bus_wdata);
    end

    // sticky status: software update first, then trigger hits win
    assign st_wr_any = wr && (sel == SEL_ST || sel == SEL_ST_SET || sel == SEL_ST_CLR);

    always_comb begin
        st_d = st_q;
        if (wr) begin
            case (sel)
                SEL_ST:     st_d = pin_mask;
                SEL_ST_SET: st_d = st_q | pin_mask;
                SEL_ST_CLR: st_d = st_q & ~pin_mask;
                default: ;
            endcase
        end
        st_d = st_d | hit;
    end

    always_ff @(posedge clk) begin
        if (rst) st_q <= '0;
        else     st_q <= st_d;
    end

    for (genvar i = 0; i < NPIN; i++) begin : g_route
        assign route_on[i] = (cfg_q[i].route == 5'd1);
    end

    assign irq     = |(st_q & route_on);
    assign pad_out = out_q;
    assign pad_oe  = oe_q;

    // read mux
    always_comb begin
        bus_rdata = '0;
        if (bus_en && !bus_we) begin
            case (sel)
                SEL_OUT: bus_rdata = 32'(out_q);
                SEL_OE:  bus_rdata = 32'(oe_q);
                SEL_IN:  bus_rdata = 32'(lvl_s);
                SEL_ST:  bus_rdata = 32'(st_q);
                SEL_CFG: bus_rdata = cfg_to_word(cfg_q[cfg_idx]);
                default: bus_rdata = '0;
            endcase
        end
    end

    // R8
    st_sticky_chk: assert property (@(posedge clk) disable iff (rst)
        !st_wr_any |=> ((st_q & $past(st_q)) == $past(st_q)));

    // R8
    st_clr_chk: assert property (@(posedge clk) disable iff (rst)
        (wr && sel == SEL_ST_CLR && ((hit & pin_mask) == '0))
            |=> ((st_q & $past(pin_mask)) == '0));

    // R10
    irq_src_chk: assert property (@(posedge clk) disable iff (rst)
        irq |-> (st_q != '0));

    // R3
    oe_set_chk: assert property (@(posedge clk) disable iff (rst)
        (wr && sel == SEL_OE_SET) |=> ((pad_oe & $past(pin_mask)) == $past(pin_mask)));

    // R2
    out_clr_chk: assert property (@(posedge clk) disable iff (rst)
        (wr && sel == SEL_OUT_CLR) |=> ((pad_out & $past(pin_mask)) == '0));

endmodule

// File: tb/test_gpio_irq_ctrl.sv
module test_gpio_irq_ctrl;
    localparam int NPIN   = 26;
    localparam int ADDR_W = 8;
    localparam logic [31:0] PMASK = 32'h03FF_FFFF;

    // word addresses
    localparam int W_OUT = 1, W_OUT_SET = 2, W_OUT_CLR = 3;
    localparam int W_OE = 8, W_OE_SET = 9, W_OE_CLR = 10;
    localparam int W_IN = 15, W_ST = 17, W_ST_SET = 18, W_ST_CLR = 19, W_CFG = 29;

    logic              clk = 1'b0;
    logic              rst;
    logic              bus_en, bus_we;
    logic [ADDR_W-1:0] bus_addr;
    logic [31:0]       bus_wdata, bus_rdata;
    logic [NPIN-1:0]   pin_in, pad_out, pad_oe;
    logic              irq;

    int total = 0;
    int bad   = 0;

    always #10 clk = ~clk;

    gpio_irq_ctrl #(.NPIN(NPIN), .ADDR_W(ADDR_W)) i_gpio_irq_ctrl (
        .clk, .rst, .bus_en, .bus_we, .bus_addr, .bus_wdata, .bus_rdata,
        .pin_in, .pad_out, .pad_oe, .irq
    );

    task automatic check(input string req, input logic [31:0] got, input logic [31:0] exp);
        total++;
        if (got !== exp) begin
            bad++;
            $display("FAIL %s got=%h exp=%h", req, got, exp);
        end
    endtask

    task automatic wr(input int a, input logic [31:0] d);
        @(negedge clk);
        bus_en = 1'b1; bus_we = 1'b1; bus_addr = ADDR_W'(a); bus_wdata = d;
        @(negedge clk);
        bus_en = 1'b0; bus_we = 1'b0;
    endtask

    task automatic rd(input int a, output logic [31:0] d);
        bus_en = 1'b1; bus_we = 1'b0; bus_addr = ADDR_W'(a);
        #1 d = bus_rdata;
        bus_en = 1'b0;
    endtask

    task automatic settle();
        repeat (3) @(negedge clk);
    endtask

    task automatic cfg(input int pin, input int kind, input int route);
        wr(W_CFG + pin, (32'(route) << 13) | (32'(kind) << 7));
    endtask

    task automatic t_reset();
        logic [31:0] d;
        check("R1 pad_out", 32'(pad_out), 0);
        check("R1 pad_oe", 32'(pad_oe), 0);
        check("R1 irq", 32'(irq), 0);
        rd(W_ST, d);      check("R1 status", d, 0);
        rd(W_CFG, d);     check("R1 cfg0", d, 0);
        rd(W_CFG + 25, d); check("R1 cfg25", d, 0);
    endtask

    task automatic t_out();
        logic [31:0] d;
        wr(W_OUT, 32'hFFFF_00F0);
        check("R2 direct", 32'(pad_out), 32'hFFFF_00F0 & PMASK);
        wr(W_OUT_SET, 32'h0000_0003);
        check("R2 set", 32'(pad_out), (32'hFFFF_00F3) & PMASK);
        wr(W_OUT_CLR, 32'h0000_0011);
        check("R2 clear", 32'(pad_out), (32'hFFFF_00E2) & PMASK);
        rd(W_OUT, d); check("R2 readback", d, 32'hFFFF_00E2 & PMASK);
        wr(W_OUT, 0);
        check("R2 zero", 32'(pad_out), 0);
    endtask

    task automatic t_oe();
        wr(W_OE_SET, 32'h0200_0001);
        check("R3 set", 32'(pad_oe), 32'h0200_0001);
        wr(W_OE_SET, 32'h0000_0100);
        check("R3 set keeps", 32'(pad_oe), 32'h0200_0101);
        wr(W_OE_CLR, 32'h0200_0000);
        check("R3 clear", 32'(pad_oe), 32'h0000_0101);
        wr(W_OE, 32'h0000_5000);
        check("R3 direct", 32'(pad_oe), 32'h0000_5000);
    endtask

    task automatic t_in();
        logic [31:0] d;
        @(negedge clk);
        pin_in = 26'h2A5_A5A5;
        @(negedge clk);
        rd(W_IN, d); check("R4 one edge not yet", d, 0);
        @(negedge clk);
        rd(W_IN, d); check("R4 synced", d, 32'h02A5_A5A5);
        pin_in = '0;
        settle();
        rd(W_IN, d); check("R4 back low", d, 0);
        wr(W_ST_CLR, 32'hFFFF_FFFF);
    endtask

    task automatic t_cfg();
        logic [31:0] d;
        wr(W_CFG + 3, 32'hFFFF_FFFF);
        rd(W_CFG + 3, d); check("R5 fields only", d, 32'h0003_E380);
        wr(W_CFG + 25, 32'h0000_2280);
        rd(W_CFG + 25, d); check("R5 last pin", d, 32'h0000_2280);
        wr(W_CFG + NPIN, 32'hFFFF_FFFF);
        rd(W_CFG + NPIN, d); check("R12 past cfg", d, 0);
        wr(W_CFG + 3, 0);
        wr(W_CFG + 25, 0);
        rd(W_CFG + 3, d); check("R5 zeroed", d, 0);
    endtask

    task automatic t_edges();
        logic [31:0] d;
        cfg(0, 1, 1);
        @(negedge clk); pin_in[0] = 1'b1; settle();
        rd(W_ST, d); check("R6 rising", d, 1);
        check("R10 irq rising", 32'(irq), 1);
        wr(W_ST_CLR, 1);
        rd(W_ST, d); check("R8 clear rising", d, 0);
        check("R10 irq drops", 32'(irq), 0);
        cfg(0, 2, 1);
        settle();
        rd(W_ST, d); check("R6 falling idle", d, 0);
        @(negedge clk); pin_in[0] = 1'b0; settle();
        rd(W_ST, d); check("R6 falling", d, 1);
        wr(W_ST_CLR, 1);
        cfg(1, 3, 1);
        @(negedge clk); pin_in[1] = 1'b1; settle();
        rd(W_ST, d); check("R6 any rise", d, 2);
        wr(W_ST_CLR, 2);
        @(negedge clk); pin_in[1] = 1'b0; settle();
        rd(W_ST, d); check("R6 any fall", d, 2);
        wr(W_ST_CLR, 32'h0000_0000);
        rd(W_ST, d); check("R8 zero clear keeps", d, 2);
        wr(W_ST_CLR, 2);
        cfg(0, 0, 0); cfg(1, 0, 0);
    endtask

    task automatic t_levels();
        logic [31:0] d;
        cfg(4, 5, 1);
        @(negedge clk); pin_in[4] = 1'b1; settle();
        rd(W_ST, d); check("R7 high", d, 32'h10);
        wr(W_ST_CLR, 32'h10);
        rd(W_ST, d); check("R7 reassert", d, 32'h10);
        check("R10 irq held", 32'(irq), 1);
        @(negedge clk); pin_in[4] = 1'b0; settle();
        wr(W_ST_CLR, 32'h10);
        rd(W_ST, d); check("R7 high gone", d, 0);
        cfg(4, 0, 0);
        cfg(5, 4, 1);
        @(negedge clk);
        rd(W_ST, d); check("R7 low", d, 32'h20);
        @(negedge clk); pin_in[5] = 1'b1; settle();
        wr(W_ST_CLR, 32'h20);
        rd(W_ST, d); check("R7 low gone", d, 0);
        cfg(5, 0, 0);
        @(negedge clk); pin_in[5] = 1'b0; settle();
    endtask

    task automatic t_unused_codes();
        logic [31:0] d;
        cfg(7, 6, 1); cfg(8, 7, 1); cfg(9, 0, 1);
        @(negedge clk); pin_in[9:7] = 3'b111; settle();
        @(negedge clk); pin_in[9:7] = 3'b000; settle();
        rd(W_ST, d); check("R11 codes 6 7 0", d, 0);
        check("R11 irq", 32'(irq), 0);
        cfg(7, 0, 0); cfg(8, 0, 0); cfg(9, 0, 0);
    endtask

    task automatic t_route();
        logic [31:0] d;
        cfg(10, 1, 2);
        @(negedge clk); pin_in[10] = 1'b1; settle();
        rd(W_ST, d); check("R10 status route2", d, 32'h400);
        check("R10 irq route2", 32'(irq), 0);
        cfg(10, 1, 1);
        check("R10 irq route1", 32'(irq), 1);
        wr(W_ST_CLR, 32'h400);
        cfg(10, 0, 0);
        @(negedge clk); pin_in[10] = 1'b0;
    endtask

    task automatic t_status_sw();
        logic [31:0] d;
        wr(W_ST_SET, 32'h0000_1000);
        rd(W_ST, d); check("R9 set alias", d, 32'h1000);
        check("R10 irq unrouted", 32'(irq), 0);
        cfg(12, 0, 1);
        check("R10 irq routed", 32'(irq), 1);
        wr(W_ST, 32'h0000_0003);
        rd(W_ST, d); check("R9 direct", d, 3);
        check("R10 irq off", 32'(irq), 0);
        wr(W_ST_CLR, 32'hFFFF_FFFF);
        rd(W_ST, d); check("R8 clear all", d, 0);
        cfg(12, 0, 0);
    endtask

    task automatic t_alias_reads();
        logic [31:0] d;
        wr(W_OUT, 32'h0000_FFFF);
        wr(W_OE, 32'h0000_FFFF);
        rd(W_OUT_SET, d); check("R12 out set", d, 0);
        rd(W_OUT_CLR, d); check("R12 out clr", d, 0);
        rd(W_OE_SET, d);  check("R12 oe set", d, 0);
        rd(W_OE_CLR, d);  check("R12 oe clr", d, 0);
        rd(W_ST_SET, d);  check("R12 st set", d, 0);
        rd(W_ST_CLR, d);  check("R12 st clr", d, 0);
        rd(0, d);         check("R12 unmapped 0", d, 0);
        rd(200, d);       check("R12 unmapped 200", d, 0);
        bus_addr = ADDR_W'(W_OUT); bus_en = 1'b0; bus_we = 1'b0;
        #1 check("R12 idle", bus_rdata, 0);
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        total++; bad++;
        $display("FAIL watchdog run hung got=timeout exp=done");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        rst = 1'b1; bus_en = 1'b0; bus_we = 1'b0; bus_addr = '0; bus_wdata = '0; pin_in = '0;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        t_reset();
        t_out();
        t_oe();
        t_in();
        t_cfg();
        t_edges();
        t_levels();
        t_unused_codes();
        t_route();
        t_status_sw();
        t_alias_reads();
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule